// File: doc/BRIEF.md
# Early-Late Gate Symbol Timing Error Detector

This block measures how far a local symbol clock sits from the true data transitions of a demodulated NRZ stream. Signed samples arrive with a strobe, together with a symbol-phase word from an external numerically controlled oscillator. The top bit of that phase word selects one of two half-symbol gates. While it is 1 the early gate integrates. While it is 0 the late gate integrates. The estimated data transition is the point where the top bit falls from 1 to 0. The early window therefore ends at that point, and the late window starts there.

Each accumulator saturates rather than wrapping. When the late window closes, the block takes the magnitudes of the held early sum and the late sum and registers their difference as a signed timing error with a one-cycle strobe. A correctly placed clock gives zero, and so does a symbol pair with no data transition. A transition inside one window reduces that window's magnitude, so the sign of the error shows the direction of the timing offset. The error feeds a loop filter, which is outside this block.

Top module: `elg_timing_detector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `err_valid` is 0 and `err_value` is 0.
- R2: A sample with `smp_valid` = 1 and `sym_phase` top bit = 1 goes to the early gate, and one with top bit = 0 goes to the late gate. A 1-to-0 change of the top bit between consecutive valid samples marks the estimated transition. At that point the early sum is held and the late gate restarts from the current sample.
- R3: On a valid sample whose top bit is 1 and whose predecessor's top bit was 0, the late window closes. On the next clock, `err_value` = |late sum| − |held early sum|, or the reverse when `LATE_MINUS_EARLY` = 0, and `err_valid` = 1. No strobe is issued until at least one early window has been held since reset.
- R4: When the data transitions coincide with the estimated transitions, the error is 0.
- R5: When the data holds one level across both windows, the error is 0.
- R6: A data transition inside the early window gives a positive error. One inside the late window gives a negative error. With amplitude 10, 16 samples per symbol and the transition 4 samples from the estimated point, the values are +80 and −80.
- R7: Each accumulator saturates at +8191 and −8192 (14-bit two's complement) instead of wrapping.
- R8: The magnitude of −8192 is taken as +8191, so `err_value` never equals −8192.
- R9: `err_valid` is high for exactly one cycle per closed window pair, and `err_value` holds its value between strobes.
- R10: Samples with `smp_valid` = 0 have no effect on the sums, the gating or the error, whatever their data and phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Signed sample, two's complement |
| sym_phase | input | 8 | Symbol phase from the oscillator; the top bit selects the gate |
| err_valid | output | 1 | One-cycle strobe when a new error is presented |
| err_value | output | 14 | Signed timing error |

## Verification
The stream is driven in four ways: with transitions aligned to the estimated point, with a constant level, and with transitions offset into the early window and into the late window. The aligned and constant cases separate a correct magnitude comparison from a signed one. The two offset cases pin down the sign convention. Long one-sided runs at full positive and full negative scale show whether the accumulators saturate or wrap, and whether the most negative sum has its magnitude clamped. Invalid samples carrying large data and a flipping phase bit are interleaved with a known stream, which shows whether the strobe qualifies both the integration and the gating.

// File: rtl/elg_pkg.sv
package elg_pkg;
  typedef enum logic {GATE_LATE = 1'b0, GATE_EARLY = 1'b1} gate_e;
endpackage

// File: rtl/elg_gate_acc.sv
module elg_gate_acc #(
  parameter int SMP_W = 8,
  parameter int ACC_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    add,
  input  logic signed [SMP_W-1:0] smp,
  output logic signed [ACC_W-1:0] acc
);
  localparam int SUM_W = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum_wide;
  logic signed [ACC_W-1:0] sum_sat;
  logic signed [ACC_W-1:0] smp_ext;

  assign smp_ext  = ACC_W'(smp);
  assign sum_wide = SUM_W'(acc) + SUM_W'(smp);

  always_comb begin
    if (sum_wide[SUM_W-1] != sum_wide[SUM_W-2])
      sum_sat = sum_wide[SUM_W-1] ? ACC_MIN : ACC_MAX;
    else
      sum_sat = sum_wide[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        acc <= '0;
    else if (start) acc <= smp_ext;
    else if (add)   acc <= sum_sat;
  end

  // R7: a full-scale positive sum stays clamped
  assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
    (add && !start && acc == ACC_MAX && smp > 0) |=> acc == ACC_MAX);
  // R7: a full-scale negative sum stays clamped
  assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
    (add && !start && acc == ACC_MIN && smp < 0) |=> acc == ACC_MIN);
  // R2: a window restarts from the current sample
  assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> acc == ACC_W'($past(smp)));
endmodule

// File: rtl/elg_abs_sat.sv
module elg_abs_sat #(
  parameter int W = 14
) (
  input  logic signed [W-1:0] val,
  output logic signed [W-1:0] mag
);
  localparam logic signed [W-1:0] V_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] V_MIN = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (val == V_MIN)   mag = V_MAX;
    else if (val < 0)   mag = -val;
    else                mag = val;
  end
endmodule

// File: rtl/elg_timing_detector.sv
module elg_timing_detector #(
  parameter int SMP_W            = 8,
  parameter int ACC_W            = 14,
  parameter int PHASE_W          = 8,
  parameter bit LATE_MINUS_EARLY = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  input  logic [SMP_W-1:0]   smp_data,
  input  logic [PHASE_W-1:0] sym_phase,
  output logic               err_valid,
  output logic [ACC_W-1:0]   err_value
);
  import elg_pkg::*;

  localparam logic signed [ACC_W-1:0] ERR_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  gate_e cur_gate;
  gate_e prev_gate;
  logic  open_early, open_late, armed_q;
  logic signed [SMP_W-1:0] smp_s;
  logic signed [ACC_W-1:0] early_acc, late_acc, early_hold;
  logic signed [ACC_W-1:0] early_mag, late_mag, diff;

  assign smp_s      = $signed(smp_data);
  assign cur_gate   = gate_e'(sym_phase[PHASE_W-1]);
  assign open_early = smp_valid && cur_gate == GATE_EARLY && prev_gate == GATE_LATE;
  assign open_late  = smp_valid && cur_gate == GATE_LATE  && prev_gate == GATE_EARLY;

  always_ff @(posedge clk) begin
    if (rst)            prev_gate <= GATE_LATE;
    else if (smp_valid) prev_gate <= cur_gate;
  end

  elg_gate_acc #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_early (
    .clk(clk), .rst(rst), .start(open_early),
    .add(smp_valid && cur_gate == GATE_EARLY), .smp(smp_s), .acc(early_acc));

  elg_gate_acc #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_late (
    .clk(clk), .rst(rst), .start(open_late),
    .add(smp_valid && cur_gate == GATE_LATE), .smp(smp_s), .acc(late_acc));

  always_ff @(posedge clk) begin
    if (rst) begin
      early_hold <= '0;
      armed_q    <= 1'b0;
    end else if (open_late) begin
      early_hold <= early_acc;
      armed_q    <= 1'b1;
    end
  end

  elg_abs_sat #(.W(ACC_W)) u_mag_early (.val(early_hold), .mag(early_mag));
  elg_abs_sat #(.W(ACC_W)) u_mag_late  (.val(late_acc),   .mag(late_mag));

  generate
    if (LATE_MINUS_EARLY) begin : g_late_first
      assign diff = late_mag - early_mag;
    end else begin : g_early_first
      assign diff = early_mag - late_mag;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_value <= '0;
    end else begin
      err_valid <= open_early && armed_q;
      if (open_early && armed_q) err_value <= diff;
    end
  end

  // R9: the strobe never lasts two cycles
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid);
  // R9: the error holds between strobes
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> $stable(err_value));
  // R8: the most negative code never appears
  assert_no_min_err_R8: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $signed(err_value) != ERR_MIN);
  // R3: no strobe before an early window has been held
  assert_armed_first_R3: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(armed_q));
endmodule

// File: tb/elg_timing_detector_tb.sv
module elg_timing_detector_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic [7:0] sym_phase = '0;
  logic       err_valid;
  logic [13:0] err_value;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  elg_timing_detector u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .sym_phase(sym_phase), .err_valid(err_valid), .err_value(err_value));

  function automatic int sat14(int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic int mag14(int v);
    if (v == -8192) return 8191;
    return (v < 0) ? -v : v;
  endfunction

  int m_early, m_late, m_hold, m_err;
  bit m_armed, m_prev, m_val;
  int last_err;

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (rst) begin
      m_early = 0; m_late = 0; m_hold = 0; m_err = 0;
      m_armed = 0; m_prev = 0; m_val = 0;
    end else begin
      m_val = 0;
      if (smp_valid) begin
        bit hi;
        int d;
        hi = sym_phase[7];
        d  = int'($signed(smp_data));
        if (hi && !m_prev) begin
          if (m_armed) begin
            m_err = mag14(m_late) - mag14(m_hold);
            m_val = 1;
          end
          m_early = d;
        end else if (!hi && m_prev) begin
          m_hold = m_early; m_armed = 1; m_late = d;
        end else if (hi) m_early = sat14(m_early + d);
        else m_late = sat14(m_late + d);
        m_prev = hi;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 strobe", int'(err_valid), int'(m_val));
      check("R3 value", int'($signed(err_value)), m_err);
      if (err_valid) last_err = int'($signed(err_value));
    end
  end

  task automatic put(bit v, int d, int ph);
    @(negedge clk);
    smp_valid = v; smp_data = 8'(d); sym_phase = 8'(ph);
  endtask

  // 16 samples per symbol; data toggles at position edge_at when tog is set
  task automatic stream(int nsym, int amp, int edge_at, bit tog, bit junk);
    int s;
    s = 1;
    for (int k = 0; k < nsym; k++)
      for (int c = 0; c < 16; c++) begin
        if (tog && c == edge_at) s = -s;
        put(1, s * amp, c * 16);
        if (junk) put(0, (c % 2) ? 127 : -128, (c % 2) ? 8'h80 : 8'h00);
      end
    for (int i = 0; i < 3; i++) put(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(err_valid), 0);
    check("R1 value in reset", int'(err_value), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(err_valid), 0);
    check("R1 value after reset", int'(err_value), 0);

    stream(6, 10, 0, 1, 0);
    check("R4 aligned transitions", last_err, 0);
    stream(6, 10, 0, 0, 0);
    check("R5 no transition", last_err, 0);
    stream(6, 10, 12, 1, 0);
    check("R6 edge in early window", last_err, 80);
    stream(6, 10, 4, 1, 0);
    check("R6 edge in late window", last_err, -80);
    check("R2 gating via late-window edge", last_err, -80);
    stream(6, 10, 12, 1, 1);
    check("R10 invalid samples ignored", last_err, 80);

    for (int i = 0; i < 100; i++) put(1, 127, 8'h80);
    for (int i = 0; i < 8; i++) put(1, 127, 8'h00);
    put(1, 0, 8'h80);
    for (int i = 0; i < 3; i++) put(0, 0, 0);
    check("R7 positive saturation", last_err, 1016 - 8191);

    for (int i = 0; i < 100; i++) put(1, -128, 8'h80);
    for (int i = 0; i < 8; i++) put(1, -128, 8'h00);
    put(1, 0, 8'h80);
    for (int i = 0; i < 3; i++) put(0, 0, 0);
    check("R8 most negative magnitude", last_err, 1024 - 8191);

    put(0, 0, 0);
    check("R9 strobe low when idle", int'(err_valid), 0);
    check("R9 value held", int'($signed(err_value)), 1024 - 8191);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule